// File: doc/BRIEF.md
# Flash Page Program Data Buffer

This block sits behind the serial command decoder of a flash device model. Once the decoder has taken a page-program opcode and its address, it pulses `load_start` with that address. It then hands over each complete data byte on `byte_valid`/`byte_data`. The block keeps the bytes in a page-sized buffer. The write pointer starts at the low address byte and wraps inside the page, and a saturating counter tracks how many bytes have been loaded.

When chip select rises, the decoder pulses `cs_rise`. At the same time it reports whether the serial bit count ended mid-byte (`cs_partial`), and the protection logic reports whether the write is allowed (`wr_permit`). If the load is acceptable and at least one byte was taken, the block walks the loaded offsets and writes one byte per clock into the external array. Each written value is the AND of the buffered byte and the current cell contents, so a bit can only change from 1 to 0. A single-cycle `done` pulse closes the commit. Erase, the program timer and protection decoding are handled elsewhere.

Top module: `flash_pp_buffer`

## Requirements
- R1: After reset `busy`, `done` and `arr_we` are all 0.
- R2: The k-th byte loaded after `load_start` (k from 0) is committed to array address {page, (off + k) mod 2^PAGE_W}. Here page is `load_addr[ADDR_W-1:PAGE_W]` and off is `load_addr[PAGE_W-1:0]`. No address outside that page, and no offset that was not loaded, is written.
- R3: Each committed byte becomes the bitwise AND of the loaded byte and the array's previous contents at that address.
- R4: When more than 2^PAGE_W bytes are loaded, only the last 2^PAGE_W loaded bytes are committed. Each lands at the offset given by R2, and earlier bytes at the same offset have no effect.
- R5: A `cs_rise` with `cs_partial` = 1 commits nothing: no array write and no `done`.
- R6: A `cs_rise` with `wr_permit` = 0 commits nothing: no array write and no `done`.
- R7: A `cs_rise` after zero loaded bytes commits nothing and raises neither `busy` nor `done`.
- R8: An accepted commit starts on the clock after `cs_rise`. It holds `busy` and `arr_we` high for exactly min(count, 2^PAGE_W) cycles, writing one byte per cycle at consecutive in-page offsets. `done` is then high for exactly one cycle.
- R9: `byte_valid` pulses that arrive while no load is open (before any `load_start`, or after `cs_rise`) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_start | input | 1 | Opens a load; samples `load_addr` |
| load_addr | input | ADDR_W | Byte address given with the program opcode |
| byte_valid | input | 1 | A complete data byte is on `byte_data` |
| byte_data | input | DATA_W | Data byte to buffer |
| cs_rise | input | 1 | Chip select has risen; ends the load |
| cs_partial | input | 1 | Bit count at `cs_rise` was not a whole number of bytes |
| wr_permit | input | 1 | Protection logic allows this program |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle pulse after the last committed byte |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Value written to the array |
| arr_rdata | input | DATA_W | Current array contents at `arr_addr` (combinational) |

## Verification
Several properties are checked on every cycle. Every array write may only clear bits relative to what it replaces. Consecutive writes stay in one page and step the offset by one. A commit starts only after an accepted chip-select rise. `done` lasts one cycle and follows a write. Other behaviour only the bench scenarios can show: which offsets were written and with which data, the overrun rule that keeps the last page-full of bytes, wrap at the page end, and that rejected or empty loads leave the array untouched. The bench covers these by comparing the whole array model against an arithmetically computed image after each scenario.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
   typedef enum logic [0:0] {
      CMT_IDLE   = 1'b0,
      CMT_ACTIVE = 1'b1
   } commit_state_e;
endpackage

// File: rtl/pp_load_track.sv
module pp_load_track #(
   parameter int ADDR_W = 20,
   parameter int PAGE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     accept,
   input  logic                     load_start,
   input  logic [ADDR_W-1:0]        load_addr,
   input  logic                     byte_valid,
   input  logic                     cs_rise,
   output logic                     loading,
   output logic                     store_we,
   output logic [PAGE_W-1:0]        wr_ptr,
   output logic [PAGE_W:0]          byte_cnt,
   output logic [ADDR_W-PAGE_W-1:0] page
);
   localparam logic [PAGE_W:0] FULL_CNT = (PAGE_W+1)'(1) << PAGE_W;

   assign store_we = loading && byte_valid && accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loading  <= 1'b0;
         wr_ptr   <= '0;
         byte_cnt <= '0;
         page     <= '0;
      end else if (load_start && accept) begin
         loading  <= 1'b1;
         wr_ptr   <= load_addr[PAGE_W-1:0];
         byte_cnt <= '0;
         page     <= load_addr[ADDR_W-1:PAGE_W];
      end else if (cs_rise) begin
         loading  <= 1'b0;
      end else if (store_we) begin
         wr_ptr   <= wr_ptr + 1'b1;
         if (byte_cnt != FULL_CNT) byte_cnt <= byte_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pp_page_store.sv
module pp_page_store #(
   parameter int PAGE_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PAGE_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PAGE_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << PAGE_W;

   logic [DATA_W-1:0] cells [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      always_ff @(posedge clk) begin
         if (we && (waddr == PAGE_W'(gi))) cells[gi] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/pp_commit_seq.sv
module pp_commit_seq
   import pp_buf_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int PAGE_W = 8,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_rise,
   input  logic                     cs_partial,
   input  logic                     wr_permit,
   input  logic                     loading,
   input  logic [PAGE_W-1:0]        wr_ptr,
   input  logic [PAGE_W:0]          byte_cnt,
   input  logic [ADDR_W-PAGE_W-1:0] page,
   input  logic [DATA_W-1:0]        buf_data,
   input  logic [DATA_W-1:0]        arr_rdata,
   output logic [PAGE_W-1:0]        rd_idx,
   output logic                     busy,
   output logic                     done,
   output logic                     arr_we,
   output logic [ADDR_W-1:0]        arr_addr,
   output logic [DATA_W-1:0]        arr_wdata
);
   commit_state_e           state;
   logic [PAGE_W:0]         left;
   logic [ADDR_W-PAGE_W-1:0] pg;
   logic                    go;

   assign go = cs_rise && loading && !cs_partial && wr_permit && (byte_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= CMT_IDLE;
         left   <= '0;
         pg     <= '0;
         rd_idx <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            CMT_IDLE: begin
               if (go) begin
                  state  <= CMT_ACTIVE;
                  rd_idx <= wr_ptr - byte_cnt[PAGE_W-1:0];
                  left   <= byte_cnt;
                  pg     <= page;
               end
            end
            CMT_ACTIVE: begin
               rd_idx <= rd_idx + 1'b1;
               left   <= left - 1'b1;
               if (left == (PAGE_W+1)'(1)) begin
                  state <= CMT_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= CMT_IDLE;
         endcase
      end
   end

   assign busy      = (state == CMT_ACTIVE);
   assign arr_we    = busy;
   assign arr_addr  = {pg, rd_idx};
   assign arr_wdata = arr_rdata & buf_data;
endmodule

// File: rtl/flash_pp_buffer.sv
module flash_pp_buffer #(
   parameter int ADDR_W = 20,
   parameter int PAGE_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_start,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              cs_rise,
   input  logic              cs_partial,
   input  logic              wr_permit,
   output logic              busy,
   output logic              done,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   input  logic [DATA_W-1:0] arr_rdata
);
   localparam int PG_W = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W > 12) begin : g_bad_page
      $error("flash_pp_buffer: PAGE_W out of range");
   end
   if (ADDR_W <= PAGE_W) begin : g_bad_addr
      $error("flash_pp_buffer: ADDR_W must exceed PAGE_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("flash_pp_buffer: DATA_W must be positive");
   end

   logic              loading, store_we;
   logic [PAGE_W-1:0] wr_ptr, rd_idx;
   logic [PAGE_W:0]   byte_cnt;
   logic [PG_W-1:0]   page;
   logic [DATA_W-1:0] buf_data;

   pp_load_track #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_track (
      .clk(clk), .rst_n(rst_n), .accept(!busy),
      .load_start(load_start), .load_addr(load_addr),
      .byte_valid(byte_valid), .cs_rise(cs_rise),
      .loading(loading), .store_we(store_we), .wr_ptr(wr_ptr),
      .byte_cnt(byte_cnt), .page(page)
   );

   pp_page_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .we(store_we), .waddr(wr_ptr), .wdata(byte_data),
      .raddr(rd_idx), .rdata(buf_data)
   );

   pp_commit_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_commit (
      .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_partial(cs_partial),
      .wr_permit(wr_permit), .loading(loading), .wr_ptr(wr_ptr),
      .byte_cnt(byte_cnt), .page(page), .buf_data(buf_data),
      .arr_rdata(arr_rdata), .rd_idx(rd_idx), .busy(busy), .done(done),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
   );
endmodule

// File: rtl/pp_buffer_chk.sv
module pp_buffer_chk #(
   parameter int ADDR_W = 20,
   parameter int PAGE_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_rise,
   input logic              cs_partial,
   input logic              wr_permit,
   input logic              busy,
   input logic              done,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr,
   input logic [DATA_W-1:0] arr_wdata,
   input logic [DATA_W-1:0] arr_rdata
);
   AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> ((arr_wdata & ~arr_rdata) == '0));                              // R3
   AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |->
         (arr_addr[ADDR_W-1:PAGE_W] == $past(arr_addr[ADDR_W-1:PAGE_W])));        // R2
   AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |->
         (arr_addr[PAGE_W-1:0] == PAGE_W'($past(arr_addr[PAGE_W-1:0]) + 1'b1))); // R8
   AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_rise && wr_permit && !cs_partial));                // R5
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                            // R8
   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(arr_we) && !arr_we));                                        // R8
endmodule

bind flash_pp_buffer pp_buffer_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_pp_buffer_bench.sv
module flash_pp_buffer_bench;
   localparam int AW    = 12;
   localparam int PW    = 8;
   localparam int DW    = 8;
   localparam int MSIZE = 1 << AW;
   localparam int PSIZE = 1 << PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_start = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic          byte_valid = 1'b0;
   logic [DW-1:0] byte_data = '0;
   logic          cs_rise = 1'b0;
   logic          cs_partial = 1'b0;
   logic          wr_permit = 1'b0;
   logic          busy, done, arr_we;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata, arr_rdata;

   logic [DW-1:0] mem [MSIZE];
   logic [DW-1:0] exp_mem [MSIZE];
   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   flash_pp_buffer #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW)) u_flash_pp_buffer (
      .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_addr(load_addr),
      .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
      .cs_partial(cs_partial), .wr_permit(wr_permit), .busy(busy), .done(done),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .arr_rdata(arr_rdata)
   );

   assign arr_rdata = mem[arr_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MSIZE; i++) mem[i] <= '1;
      end else if (arr_we) begin
         mem[arr_addr] <= arr_wdata;
      end
   end

   function automatic logic [DW-1:0] pat(int seed, int k);
      return DW'((k * 29 + seed) ^ (k >> 3));
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic check_mem(string req);
      int bad = -1;
      for (int i = 0; i < MSIZE; i++)
         if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
      if (bad < 0) check(1'b1, req, 0, 0);
      else check(1'b0, {req, " array byte"}, int'(mem[bad]), int'(exp_mem[bad]));
   endtask

   // one program session; sends n bytes, closes with cs_rise, observes the commit
   task automatic run_prog(int pg, int off, int n, int seed, bit partial, bit permit,
                           string req);
      int busy_cnt = 0;
      int done_cnt = 0;
      bit valid = !partial && permit && (n > 0);
      int first = (n > PSIZE) ? n - PSIZE : 0;
      @(negedge clk);
      load_start = 1'b1;
      load_addr  = AW'((pg << PW) | off);
      @(negedge clk);
      load_start = 1'b0;
      for (int k = 0; k < n; k++) begin
         byte_valid = 1'b1;
         byte_data  = pat(seed, k);
         @(negedge clk);
      end
      byte_valid = 1'b0;
      cs_rise    = 1'b1;
      cs_partial = partial;
      wr_permit  = permit;
      @(negedge clk);
      cs_rise    = 1'b0;
      cs_partial = 1'b0;
      wr_permit  = 1'b0;
      for (int c = 0; c < PSIZE + 8; c++) begin
         if (busy) busy_cnt++;
         if (done) done_cnt++;
         @(negedge clk);
      end
      if (valid)
         for (int k = first; k < n; k++)
            exp_mem[(pg << PW) | ((off + k) % PSIZE)] &= pat(seed, k);
      check(busy_cnt == (valid ? n - first : 0), {req, " busy cycles (R8)"},
            busy_cnt, valid ? n - first : 0);
      check(done_cnt == (valid ? 1 : 0), {req, " done pulses (R8)"},
            done_cnt, valid ? 1 : 0);
      check_mem(req);
   endtask

   initial begin
      for (int i = 0; i < MSIZE; i++) exp_mem[i] = '1;
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && arr_we === 1'b0, "R1 reset outputs",
            {busy, done, arr_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0 && done === 1'b0 && arr_we === 1'b0, "R1 after release",
            {busy, done, arr_we}, 0);
      // R9: stray bytes before any load
      for (int k = 0; k < 4; k++) begin
         byte_valid = 1'b1; byte_data = 8'h00; @(negedge clk);
      end
      byte_valid = 1'b0;
      run_prog(3, 8'h10, 5, 7, 1'b0, 1'b1, "R2 short load");
      run_prog(5, 8'hFC, 10, 90, 1'b0, 1'b1, "R2 wrap in page");
      run_prog(3, 8'h0E, 9, 200, 1'b0, 1'b1, "R3 AND with old data");
      run_prog(7, 8'h20, 300, 3, 1'b0, 1'b1, "R4 overrun keeps last");
      run_prog(9, 8'h80, 256, 55, 1'b0, 1'b1, "R8 full page");
      run_prog(2, 8'h00, 4, 11, 1'b1, 1'b1, "R5 partial byte");
      run_prog(2, 8'h40, 6, 12, 1'b0, 1'b0, "R6 no permit");
      run_prog(2, 8'h40, 0, 13, 1'b0, 1'b1, "R7 zero bytes");
      // R9: bytes after the load closed must not enter the next commit
      for (int k = 0; k < 3; k++) begin
         byte_valid = 1'b1; byte_data = 8'h00; @(negedge clk);
      end
      byte_valid = 1'b0;
      run_prog(11, 8'h33, 1, 77, 1'b0, 1'b1, "R9 stray bytes ignored");
      run_prog(15, 8'hFF, 2, 140, 1'b0, 1'b1, "R2 last page wrap");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule